// File: doc/BRIEF.md
# Synthesizer Configuration Register with Serial and Parallel Load

This block stores the configuration word of a frequency synthesizer. The word has three fields. The first is a 9-bit feedback divider value. The second is a 2-bit output divider code. The third is a 3-bit test-mode select. Two load paths write the word, and they work independently of each other.

The first path is a three-wire serial port: data, clock and load strobe. The serial clock shifts a 14-bit chain. Holding the serial strobe high makes the stored word follow that chain. When the strobe falls, the word freezes.

The second path is a set of parallel divider pins with an active-low strobe. While the strobe is low, the divider and output-code fields follow the pins. When the strobe rises, they freeze. The test field is not touched by this path.

The strobes and the serial lines are asynchronous to the block. Each one passes through a synchronizer clocked by a fast system clock. The latch behaviour is then rebuilt from the synchronized levels and edges. When reset is released, the word takes the parallel pin values once, so a usable configuration exists even if the serial port is never used. The block emits a single-cycle update pulse whenever the stored word changes.

Top module: `synth_cfg_reg`

## Requirements
- R1: While `rst_n` is low, the outputs read divider 9'h1FF, code 2'b11 and test 3'b000. Within three clocks after reset is released, `cfg_m` and `cfg_n` equal `par_m` and `par_n`, and `cfg_t` stays 0.
- R2: Each rising edge of `ser_clk` shifts one bit of `ser_data` into a 14-bit chain. The word is sent as the test field first, then the output code, then the divider. Each field is sent MSB first, so the final bit shifted is divider bit 0.
- R3: While `ser_ld` is high, all three output fields track the chain. Chain bits [13:11] drive `cfg_t`, bits [10:9] drive `cfg_n` and bits [8:0] drive `cfg_m`. Further shifts made during this time show on the outputs.
- R4: After `ser_ld` falls, further serial shifting leaves all outputs unchanged.
- R5: While `par_ld_n` is low (and `ser_ld` is low), `cfg_m` and `cfg_n` follow `par_m` and `par_n`. `cfg_t` is left unchanged.
- R6: While `par_ld_n` is high, changes on `par_m` and `par_n` have no effect on the outputs.
- R7: When both strobes are active at the same time, the outputs take the serial chain contents.
- R8: `cfg_upd` is high for exactly those clocks in which the output word differs from its value one clock earlier. Each load that changes the word gives a single one-clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it must be much faster than the serial clock and the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial configuration data |
| ser_clk | input | 1 | Serial shift clock; the chain shifts on its rising edge |
| ser_ld | input | 1 | Serial load strobe; the word is transparent to the chain while this is high |
| par_ld_n | input | 1 | Parallel load strobe, active low; the word is transparent to the pins while this is low |
| par_m | input | 9 | Parallel feedback divider value |
| par_n | input | 2 | Parallel output divider code |
| cfg_m | output | 9 | Stored feedback divider value |
| cfg_n | output | 2 | Stored output divider code |
| cfg_t | output | 3 | Stored test-mode select |
| cfg_upd | output | 1 | One-clock pulse when the stored word changes |

## Verification
The assertions assume three things about the inputs:
- Each strobe and serial-clock level lasts several system clocks.
- `ser_data` is stable around each serial clock edge.
- The parallel pins stay steady from before the parallel strobe falls until the synchronized strobe has risen.

The bench paces every serial edge and strobe level four to six system clocks apart. It changes the parallel pins only while their strobe has been high for longer than the synchronizer depth. The sweeps cover every output code and every test value on the serial path, and a stride through the divider range on the parallel path.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  parameter int unsigned M_W = 9;
  parameter int unsigned N_W = 2;
  parameter int unsigned T_W = 3;
  localparam int unsigned CHAIN_W = M_W + N_W + T_W;

  // field order matches the serial shift order: test bits arrive first
  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_word_t;

  localparam cfg_word_t CFG_RESET = '{t: '0, n: '1, m: '1};
endpackage

// File: rtl/sync_bit.sv
module sync_bit #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/ser_shift.sv
module ser_shift
  import synth_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_lvl,
  input  logic               sdat_lvl,
  output logic [CHAIN_W-1:0] chain
);
  logic               sclk_prev_q;
  logic               shift_en;
  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  assign shift_en = sclk_lvl & ~sclk_prev_q;

  always_comb begin
    chain_d = chain_q;
    if (shift_en) chain_d = {chain_q[CHAIN_W-2:0], sdat_lvl};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      chain_q     <= '0;
    end else begin
      sclk_prev_q <= sclk_lvl;
      chain_q     <= chain_d;
    end
  end

  assign chain = chain_q;

  AST_CHAIN_STILL_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_lvl && !sclk_prev_q) |=> $stable(chain_q)); // R2
  AST_CHAIN_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_lvl && !sclk_prev_q) |=> (chain_q[0] == $past(sdat_lvl))); // R2
endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
  import synth_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_lvl,
  input  logic               par_lvl_n,
  input  logic [CHAIN_W-1:0] chain,
  input  logic [M_W-1:0]     pin_m,
  input  logic [N_W-1:0]     pin_n,
  output cfg_word_t          cfg,
  output logic               upd
);
  cfg_word_t cfg_q, cfg_d;
  logic      init_q, init_d;
  logic      upd_q, upd_d;

  always_comb begin
    cfg_d  = cfg_q;
    init_d = 1'b0;
    if (ser_lvl) begin
      cfg_d = cfg_word_t'(chain);
    end else if (init_q || !par_lvl_n) begin
      cfg_d.m = pin_m;
      cfg_d.n = pin_n;
    end
    upd_d = (cfg_d != cfg_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RESET;
      init_q <= 1'b1;
      upd_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      init_q <= init_d;
      upd_q  <= upd_d;
    end
  end

  assign cfg = cfg_q;
  assign upd = upd_q;

  AST_SERIAL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    ser_lvl |=> (cfg_q == cfg_word_t'($past(chain)))); // R7
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_lvl && par_lvl_n && !init_q) |=> $stable(cfg_q)); // R6
  AST_TEST_FIELD_SERIAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_lvl |=> $stable(cfg_q.t)); // R5
  AST_UPD_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q == (cfg_q != $past(cfg_q))); // R8
endmodule

// File: rtl/synth_cfg_reg.sv
module synth_cfg_reg
  import synth_cfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_data,
  input  logic           ser_clk,
  input  logic           ser_ld,
  input  logic           par_ld_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  output logic [M_W-1:0] cfg_m,
  output logic [N_W-1:0] cfg_n,
  output logic [T_W-1:0] cfg_t,
  output logic           cfg_upd
);
  logic               sdat_lvl, sclk_lvl, sld_lvl, pld_lvl_n;
  logic [CHAIN_W-1:0] chain;
  cfg_word_t          cfg;

  sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d(ser_data), .q(sdat_lvl));
  sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d(ser_clk), .q(sclk_lvl));
  sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sld (
    .clk(clk), .rst_n(rst_n), .d(ser_ld), .q(sld_lvl));
  sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pld (
    .clk(clk), .rst_n(rst_n), .d(par_ld_n), .q(pld_lvl_n));

  ser_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_lvl(sclk_lvl), .sdat_lvl(sdat_lvl),
    .chain(chain));

  cfg_latch u_latch (
    .clk(clk), .rst_n(rst_n), .ser_lvl(sld_lvl), .par_lvl_n(pld_lvl_n),
    .chain(chain), .pin_m(par_m), .pin_n(par_n), .cfg(cfg), .upd(cfg_upd));

  assign cfg_m = cfg.m;
  assign cfg_n = cfg.n;
  assign cfg_t = cfg.t;
endmodule

// File: tb/synth_cfg_reg_tb.sv
module synth_cfg_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_data = 1'b0, ser_clk = 1'b0, ser_ld = 1'b0, par_ld_n = 1'b1;
  logic [8:0] par_m = 9'h0A5;
  logic [1:0] par_n = 2'b10;
  logic [8:0] cfg_m;
  logic [1:0] cfg_n;
  logic [2:0] cfg_t;
  logic       cfg_upd;

  int n_chk = 0, n_bad = 0, mon_bad = 0, pulses = 0;
  bit done = 1'b0;
  logic [13:0] prev_w;

  synth_cfg_reg u_dut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_ld(ser_ld), .par_ld_n(par_ld_n), .par_m(par_m), .par_n(par_n),
    .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t), .cfg_upd(cfg_upd));

  always #5 clk = ~clk;

  // R8 model: pulse expected in exactly the cycles where the word moved
  always @(negedge clk) begin
    if (rst_n) begin
      if (cfg_upd !== ({cfg_t, cfg_n, cfg_m} != prev_w)) mon_bad++;
      if (cfg_upd) pulses++;
    end
    prev_w = {cfg_t, cfg_n, cfg_m};
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [8:0] em, input logic [1:0] en,
                       input logic [2:0] et);
    n_chk++;
    if (cfg_m !== em || cfg_n !== en || cfg_t !== et) begin
      n_bad++;
      $display("FAIL %s: got m=%h n=%h t=%h expected m=%h n=%h t=%h",
               req, cfg_m, cfg_n, cfg_t, em, en, et);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_data = b;
    settle(4);
    ser_clk = 1'b1;
    settle(4);
    ser_clk = 1'b0;
    settle(4);
  endtask

  task automatic shift_word(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic ser_load();
    ser_ld = 1'b1;
    settle(6);
    ser_ld = 1'b0;
    settle(6);
  endtask

  task automatic par_load(input logic [8:0] m, input logic [1:0] n);
    par_m = m;
    par_n = n;
    settle(2);
    par_ld_n = 1'b0;
    settle(6);
    par_ld_n = 1'b1;
    settle(6);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [8:0]  cur_m;
    logic [1:0]  cur_n;
    logic [2:0]  cur_t;
    logic [13:0] w;
    int          p0;

    settle(3);
    check("R1 reset defaults", 9'h1FF, 2'b11, 3'b000);
    rst_n = 1'b1;
    settle(3);
    check("R1 power-up load", 9'h0A5, 2'b10, 3'b000);
    cur_m = 9'h0A5; cur_n = 2'b10; cur_t = 3'b000;

    // R2 R3 serial sweep over every T and N
    for (int t = 0; t < 8; t++) begin
      for (int n = 0; n < 4; n++) begin
        logic [8:0] m;
        m = 9'((t * 61 + n * 97 + 5) % 512);
        w = {3'(t), 2'(n), m};
        shift_word(w);
        check("R2 before load", cur_m, cur_n, cur_t);
        p0 = pulses;
        ser_load();
        check("R3 serial load", m, 2'(n), 3'(t));
        check_int("R8 one pulse per load", pulses - p0,
                  ({3'(t), 2'(n), m} != {cur_t, cur_n, cur_m}) ? 1 : 0);
        cur_m = m; cur_n = 2'(n); cur_t = 3'(t);
      end
    end

    // R3 transparency: a shift while strobe is high shows at once
    w = {3'b101, 2'b01, 9'h133};
    shift_word(w);
    ser_ld = 1'b1;
    settle(6);
    check("R3 transparent", 9'h133, 2'b01, 3'b101);
    shift_bit(1'b0);
    w = {w[12:0], 1'b0};
    check("R3 follows extra shift", w[8:0], w[10:9], w[13:11]);
    ser_ld = 1'b0;
    settle(6);
    cur_m = w[8:0]; cur_n = w[10:9]; cur_t = w[13:11];
    // R4 hold after strobe falls
    shift_word({3'b010, 2'b10, 9'h0C3});
    check("R4 hold after fall", cur_m, cur_n, cur_t);

    // R5 parallel sweep, test field kept
    for (int m = 3; m < 512; m += 37) begin
      for (int n = 0; n < 4; n++) begin
        par_load(9'(m), 2'(n));
        check("R5 parallel load", 9'(m), 2'(n), cur_t);
        cur_m = 9'(m); cur_n = 2'(n);
      end
    end

    // R6 pins ignored while strobe high
    par_m = 9'h1AA; par_n = 2'b00;
    settle(8);
    check("R6 pins ignored", cur_m, cur_n, cur_t);

    // R7 both strobes active
    shift_word({3'b110, 2'b11, 9'h055});
    par_m = 9'h0F0; par_n = 2'b01;
    settle(2);
    par_ld_n = 1'b0; ser_ld = 1'b1;
    settle(8);
    check("R7 serial wins", 9'h055, 2'b11, 3'b110);
    par_ld_n = 1'b1; ser_ld = 1'b0;
    settle(8);
    check("R7 after release", 9'h055, 2'b11, 3'b110);

    // R8 reload of identical word gives no pulse
    p0 = pulses;
    ser_load();
    check_int("R8 no pulse on same word", pulses - p0, 0);
    check_int("R8 pulse only on change", mon_bad, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule